// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block sits on the read path of a flash device. It replaces selected bits of the array data with status bits while an internal program or erase is running, or while an erase is suspended. A host that polls any address can then tell whether the operation has finished. It can also tell which sector an erase belongs to, and whether that erase is active or suspended. The array itself and the command decoder are outside the block. The decoder supplies one-cycle command pulses and the target address. Completion of the internal operation arrives as a one-cycle `op_done` pulse.

Three bit positions carry status:
- The polling bit is bit 7 by default. It shows the complement of the data being written, or a fixed erase level.
- The busy toggle is bit 6 by default. It inverts on every read strobe while an operation is active.
- The sector toggle is bit 2 by default. It inverts only on reads that fall inside the sector being erased or suspended.

All other bits always pass the array data. The output is combinational from the current read address and array data. The two toggle flip-flops advance at the clock edge that ends a read strobe.

The sector of an address is its bits `[ADDR_W-1:SECT_LSB]`. With the defaults that is `[11:8]`.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, and whenever no operation is active or suspended, `dq_out` equals `arr_data` on every bit.
- R2: When idle, a `cmd_prog` pulse starts a program at `cmd_addr` and latches `pgm_poll_d`. While that program runs:
  - A read at that address returns the inverse of the latched bit on bit 7.
  - At any other address, bit 7 is the array bit.
  - Bits other than 7, 6 and 2 are array data.
  - After `op_done`, reads return true array data.
- R3: During a program, an erase, or a program under suspend, bit 6 behaves as follows:
  - It reads 0 on the first read strobe after the operation starts.
  - It inverts on each later strobe, at any address.
  - Once the operation is done, bit 6 is array data again.
- R4: During a program, a read at the target address returns 0 on bit 2 on every read, whatever the array holds.
- R5: When idle, a `cmd_erase` pulse starts an erase of the sector of `cmd_addr`.
  - Reads inside that sector return 0 on bit 7. Bit 2 reads 0 on the first in-sector read and inverts on each later in-sector read.
  - Reads outside the sector return array bits 7 and 2 and do not advance bit 2.
  - After `op_done`, reads return array data.
- R6: A `cmd_susp` pulse during an erase suspends it. Reads inside the suspended sector return 1 on bit 7 and 1 on bit 6. Bit 2 continues its sequence from the value it had when the erase was suspended.
- R7: While suspended, reads outside the suspended sector return array data on all bits and advance no toggle.
- R8: While suspended, a `cmd_prog` to another sector starts a program:
  - At the target address, bit 7 is the inverse of the latched bit.
  - Bit 6 toggles from 0 at any address.
  - Bit 2 is array data.
  - `op_done` returns the block to the suspended state with the bit 2 sequence preserved.
- R9: While suspended, a `cmd_prog` whose address lies in the suspended sector is ignored.
- R10: A `cmd_resume` pulse while suspended and idle returns to the erase. Bit 7 reads 0 in the sector, and bits 6 and 2 continue their sequences.
- R11: Start commands received while a program or erase is active are ignored. The original target address, latched data bit and sector remain in force.
- R12: A read strobe coincident with a start command reports the state before the command. A read strobe coincident with `op_done` reports the status of the finishing operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_prog | input | 1 | One-cycle pulse: start a program at `cmd_addr` |
| cmd_erase | input | 1 | One-cycle pulse: start an erase of the sector of `cmd_addr` |
| cmd_susp | input | 1 | One-cycle pulse: suspend the running erase |
| cmd_resume | input | 1 | One-cycle pulse: resume the suspended erase |
| op_done | input | 1 | One-cycle pulse: the internal program or erase has finished |
| cmd_addr | input | ADDR_W | Target address of a start command |
| pgm_poll_d | input | 1 | Polling-position bit of the data being programmed |
| rd_stb | input | 1 | Read strobe; one cycle per completed read |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | True array data at `rd_addr` |
| dq_out | output | DATA_W | Read data with status bits overlaid |

## Verification
A read strobe can fall in the same cycle as a state change. With a start command, the read must still see idle array data, and the first status read afterwards must show 0 on both toggles. With `op_done`, the read must still see the finishing operation's polling and toggle values, and the next read must see plain array data. The bench drives both pairings by raising the read strobe together with the command or completion pulse, and judges the result against a scoreboard entry computed from the state before the edge. A separate model keeps its own toggle sequence across suspend, program under suspend and resume, and checks that no stray read advanced either toggle.

// File: rtl/flst_pkg.sv
package flst_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_SUSP  = 3'd3,
    M_SPROG = 3'd4
  } mode_e;

  function automatic logic mode_busy(input mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_SPROG);
  endfunction

endpackage

// File: rtl/flst_rst_sync.sv
module flst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = sh_q[STAGES-1];

endmodule

// File: rtl/flst_ctrl.sv
module flst_ctrl
  import flst_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SECT_LSB = 8,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic              op_done,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pgm_poll_d,
  output mode_e             mode,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              tgt_poll,
  output logic [SECT_W-1:0] er_sect,
  output logic              clr_busy_tog,
  output logic              clr_sect_tog
);

  mode_e             mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              poll_q, poll_d;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic              cap_prog, cap_erase;
  logic              cmd_sect_hit;

  assign cmd_sect_hit = (cmd_addr[ADDR_W-1:SECT_LSB] == sect_q);

  // next-state
  always_comb begin
    mode_d       = mode_q;
    cap_prog     = 1'b0;
    cap_erase    = 1'b0;
    clr_busy_tog = 1'b0;
    clr_sect_tog = 1'b0;
    unique case (mode_q)
      M_IDLE: begin
        if (cmd_prog) begin
          mode_d       = M_PROG;
          cap_prog     = 1'b1;
          clr_busy_tog = 1'b1;
          clr_sect_tog = 1'b1;
        end else if (cmd_erase) begin
          mode_d       = M_ERASE;
          cap_erase    = 1'b1;
          clr_busy_tog = 1'b1;
          clr_sect_tog = 1'b1;
        end
      end
      M_PROG: begin
        if (op_done) mode_d = M_IDLE;
      end
      M_ERASE: begin
        if (op_done)       mode_d = M_IDLE;
        else if (cmd_susp) mode_d = M_SUSP;
      end
      M_SUSP: begin
        if (cmd_resume) begin
          mode_d = M_ERASE;
        end else if (cmd_prog && !cmd_sect_hit) begin
          mode_d       = M_SPROG;
          cap_prog     = 1'b1;
          clr_busy_tog = 1'b1;
        end
      end
      M_SPROG: begin
        if (op_done) mode_d = M_SUSP;
      end
      default: mode_d = M_IDLE;
    endcase
  end

  always_comb begin
    addr_d = addr_q;
    poll_d = poll_q;
    sect_d = sect_q;
    if (cap_prog) begin
      addr_d = cmd_addr;
      poll_d = pgm_poll_d;
    end
    if (cap_erase) begin
      sect_d = cmd_addr[ADDR_W-1:SECT_LSB];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      addr_q <= '0;
      poll_q <= 1'b0;
      sect_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (cap_prog) begin
        addr_q <= addr_d;
        poll_q <= poll_d;
      end
      if (cap_erase) begin
        sect_q <= sect_d;
      end
    end
  end

  assign mode     = mode_q;
  assign tgt_addr = addr_q;
  assign tgt_poll = poll_q;
  assign er_sect  = sect_q;

  // R11: an active program only leaves by completing
  p_prog_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PROG && !op_done) |=> (mode_q == M_PROG));

  // R9: a program under suspend never targets the suspended sector
  p_sprog_sect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_SUSP && mode_q == M_SPROG)
      |-> (addr_q[ADDR_W-1:SECT_LSB] != sect_q));

endmodule

// File: rtl/flst_tog.sv
module flst_tog (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic q
);

  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr)       q_d = 1'b0;
    else if (flip) q_d = ~q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else if (clr || flip) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/flst_mux.sv
module flst_mux
  import flst_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int BUSY_BIT = 6,
  parameter int SECT_BIT = 2
) (
  input  mode_e             mode,
  input  logic              addr_hit,
  input  logic              sect_hit,
  input  logic              tgt_poll,
  input  logic              busy_tog,
  input  logic              sect_tog,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dq
);

  logic poll_v, busy_v, sect_v;

  always_comb begin
    poll_v = arr_data[POLL_BIT];
    busy_v = arr_data[BUSY_BIT];
    sect_v = arr_data[SECT_BIT];
    unique case (mode)
      M_PROG: begin
        busy_v = busy_tog;
        if (addr_hit) begin
          poll_v = ~tgt_poll;
          sect_v = sect_tog;
        end
      end
      M_ERASE: begin
        busy_v = busy_tog;
        if (sect_hit) begin
          poll_v = 1'b0;
          sect_v = sect_tog;
        end
      end
      M_SUSP: begin
        if (sect_hit) begin
          poll_v = 1'b1;
          busy_v = 1'b1;
          sect_v = sect_tog;
        end
      end
      M_SPROG: begin
        busy_v = busy_tog;
        if (addr_hit) poll_v = ~tgt_poll;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (g == POLL_BIT) begin : g_poll
      assign dq[g] = poll_v;
    end else if (g == BUSY_BIT) begin : g_busy
      assign dq[g] = busy_v;
    end else if (g == SECT_BIT) begin : g_sect
      assign dq[g] = sect_v;
    end else begin : g_pass
      assign dq[g] = arr_data[g];
    end
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flst_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 8,
  parameter int POLL_BIT = 7,
  parameter int BUSY_BIT = 6,
  parameter int SECT_BIT = 2,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic              op_done,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pgm_poll_d,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dq_out
);

  logic              rst_s_n;
  mode_e             mode;
  logic [ADDR_W-1:0] tgt_addr;
  logic              tgt_poll;
  logic [SECT_W-1:0] er_sect;
  logic              clr_busy_tog, clr_sect_tog;
  logic              addr_hit, sect_hit, busy;
  logic [1:0]        tog_clr, tog_flip, tog_q;

  flst_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  flst_ctrl #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .cmd_prog     (cmd_prog),
    .cmd_erase    (cmd_erase),
    .cmd_susp     (cmd_susp),
    .cmd_resume   (cmd_resume),
    .op_done      (op_done),
    .cmd_addr     (cmd_addr),
    .pgm_poll_d   (pgm_poll_d),
    .mode         (mode),
    .tgt_addr     (tgt_addr),
    .tgt_poll     (tgt_poll),
    .er_sect      (er_sect),
    .clr_busy_tog (clr_busy_tog),
    .clr_sect_tog (clr_sect_tog)
  );

  assign addr_hit = (rd_addr == tgt_addr);
  assign sect_hit = (rd_addr[ADDR_W-1:SECT_LSB] == er_sect);
  assign busy     = mode_busy(mode);

  // index 0: busy toggle, index 1: sector toggle
  assign tog_clr[0]  = clr_busy_tog;
  assign tog_flip[0] = rd_stb && busy;
  assign tog_clr[1]  = clr_sect_tog;
  assign tog_flip[1] = rd_stb && sect_hit && (mode == M_ERASE || mode == M_SUSP);

  for (genvar t = 0; t < 2; t++) begin : g_tog
    flst_tog u_tog (
      .clk  (clk),
      .rst_n(rst_s_n),
      .clr  (tog_clr[t]),
      .flip (tog_flip[t]),
      .q    (tog_q[t])
    );
  end

  flst_mux #(
    .DATA_W  (DATA_W),
    .POLL_BIT(POLL_BIT),
    .BUSY_BIT(BUSY_BIT),
    .SECT_BIT(SECT_BIT)
  ) u_mux (
    .mode     (mode),
    .addr_hit (addr_hit),
    .sect_hit (sect_hit),
    .tgt_poll (tgt_poll),
    .busy_tog (tog_q[0]),
    .sect_tog (tog_q[1]),
    .arr_data (arr_data),
    .dq       (dq_out)
  );

  // R1: nothing overlaid while idle
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == M_IDLE) |-> (dq_out == arr_data));

  // R3: back-to-back reads in one busy mode see bit 6 alternate
  p_busy_alt_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb && busy && $past(rd_stb) && $past(busy) && ($past(mode) == mode))
      |-> (dq_out[BUSY_BIT] != $past(dq_out[BUSY_BIT])));

  // R3: both toggles start from 0 when an operation starts from idle
  p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(mode) == M_IDLE && mode != M_IDLE) |-> (!tog_q[0] && !tog_q[1]));

  // R4: the sector toggle stays at 0 through a program
  p_prog_sect_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == M_PROG) |-> !tog_q[1]);

  // R5: erase polls 0 inside the sector
  p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == M_ERASE && sect_hit) |-> !dq_out[POLL_BIT]);

  // R6: suspended sector reads 1 on bits 7 and 6
  p_susp_sect_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == M_SUSP && sect_hit) |-> (dq_out[POLL_BIT] && dq_out[BUSY_BIT]));

  // R7: other sectors read plain data while suspended
  p_susp_other_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == M_SUSP && !sect_hit) |-> (dq_out == arr_data));

endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DA = 16'hA5C3; // b7=1 b6=1 b2=0
  localparam logic [15:0] DB = 16'h5A3C; // b7=0 b6=0 b2=1

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_prog, cmd_erase, cmd_susp, cmd_resume, op_done;
  logic [11:0] cmd_addr;
  logic        pgm_poll_d;
  logic        rd_stb;
  logic [11:0] rd_addr;
  logic [15:0] arr_data;
  logic [15:0] dq_out;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done_f = 0;
  logic m6, m2;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_prog   (cmd_prog),
    .cmd_erase  (cmd_erase),
    .cmd_susp   (cmd_susp),
    .cmd_resume (cmd_resume),
    .op_done    (op_done),
    .cmd_addr   (cmd_addr),
    .pgm_poll_d (pgm_poll_d),
    .rd_stb     (rd_stb),
    .rd_addr    (rd_addr),
    .arr_data   (arr_data),
    .dq_out     (dq_out)
  );

  function automatic logic [15:0] mk(input logic [15:0] a, input logic b7,
                                     input logic b6, input logic b2);
    logic [15:0] r;
    r = a; r[7] = b7; r[6] = b6; r[2] = b2;
    return r;
  endfunction

  // driver: one cycle of stimulus; c = {prog, erase, susp, resume, done}
  task automatic drv(input logic [4:0] c, input logic rd, input logic [11:0] ra,
                     input logic [15:0] ar, input logic [11:0] ca, input logic pd,
                     input logic [15:0] ex, input string tg);
    @(posedge clk); #1;
    {cmd_prog, cmd_erase, cmd_susp, cmd_resume, op_done} = c;
    rd_stb = rd; rd_addr = ra; arr_data = ar; cmd_addr = ca; pgm_poll_d = pd;
    if (rd) begin
      exp_q.push_back(ex);
      tag_q.push_back(tg);
    end
  endtask

  task automatic rd(input logic [11:0] ra, input logic [15:0] ar,
                    input logic [15:0] ex, input string tg);
    drv(5'b00000, 1'b1, ra, ar, 12'h000, 1'b0, ex, tg);
  endtask

  task automatic cmd(input logic [4:0] c, input logic [11:0] ca, input logic pd);
    drv(c, 1'b0, 12'h000, 16'h0000, ca, pd, 16'h0000, "");
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (rd_stb && rst_n) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: got %h expected none", dq_out);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dq_out !== e) begin
          n_fail++;
          $display("FAIL %s: addr %h got %h expected %h", t, rd_addr, dq_out, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_f) begin
      n_cmp++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  localparam logic [4:0] CP = 5'b10000, CE = 5'b01000, CS = 5'b00100,
                         CR = 5'b00010, CD = 5'b00001;

  initial begin
    rst_n = 1'b0;
    {cmd_prog, cmd_erase, cmd_susp, cmd_resume, op_done} = '0;
    rd_stb = 1'b0; rd_addr = '0; arr_data = '0; cmd_addr = '0; pgm_poll_d = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(12'h123, DA, DA, "R1");
    rd(12'h456, DB, DB, "R1");

    // R12 start together with a read: read sees idle data
    drv(CP, 1'b1, 12'h210, DA, 12'h210, 1'b1, DA, "R12");
    m6 = 0; m2 = 0;
    rd(12'h210, DA, mk(DA, 1'b0, m6, 1'b0), "R2"); m6 = ~m6;
    rd(12'h210, DB, mk(DB, 1'b0, m6, 1'b0), "R4"); m6 = ~m6;
    rd(12'h300, DB, mk(DB, DB[7], m6, DB[2]), "R3"); m6 = ~m6;
    cmd(CP, 12'h300, 1'b0);   // R11 ignored
    rd(12'h210, DA, mk(DA, 1'b0, m6, 1'b0), "R11"); m6 = ~m6;
    // R12 completion together with a read: still status
    drv(CD, 1'b1, 12'h210, DA, 12'h000, 1'b0, mk(DA, 1'b0, m6, 1'b0), "R12");
    rd(12'h210, DA, DA, "R2");
    rd(12'h300, DB, DB, "R3");

    // erase of sector 5
    cmd(CE, 12'h5C0, 1'b0);
    m6 = 0; m2 = 0;
    rd(12'h512, DA, mk(DA, 1'b0, m6, m2), "R5"); m6 = ~m6; m2 = ~m2;
    rd(12'h5FF, DB, mk(DB, 1'b0, m6, m2), "R5"); m6 = ~m6; m2 = ~m2;
    rd(12'h700, DA, mk(DA, DA[7], m6, DA[2]), "R5"); m6 = ~m6;
    rd(12'h500, DA, mk(DA, 1'b0, m6, m2), "R5"); m6 = ~m6; m2 = ~m2;

    // suspend
    cmd(CS, 12'h000, 1'b0);
    rd(12'h520, DB, mk(DB, 1'b1, 1'b1, m2), "R6"); m2 = ~m2;
    rd(12'h520, DA, mk(DA, 1'b1, 1'b1, m2), "R6"); m2 = ~m2;
    rd(12'h800, DB, DB, "R7");
    rd(12'h801, DA, DA, "R7");
    cmd(CP, 12'h530, 1'b1);   // R9 ignored: suspended sector
    rd(12'h530, DB, mk(DB, 1'b1, 1'b1, m2), "R9"); m2 = ~m2;

    // program under suspend in sector 8
    cmd(CP, 12'h840, 1'b0);
    m6 = 0;
    rd(12'h840, DB, mk(DB, 1'b1, m6, DB[2]), "R8"); m6 = ~m6;
    rd(12'h840, DA, mk(DA, 1'b1, m6, DA[2]), "R8"); m6 = ~m6;
    rd(12'h900, DB, mk(DB, DB[7], m6, DB[2]), "R8"); m6 = ~m6;
    rd(12'h540, DA, mk(DA, DA[7], m6, DA[2]), "R8"); m6 = ~m6;
    cmd(CD, 12'h000, 1'b0);
    rd(12'h540, DB, mk(DB, 1'b1, 1'b1, m2), "R8"); m2 = ~m2;
    rd(12'h840, DA, DA, "R7");

    // resume
    cmd(CR, 12'h000, 1'b0);
    rd(12'h5AA, DA, mk(DA, 1'b0, m6, m2), "R10"); m6 = ~m6; m2 = ~m2;
    rd(12'h5AB, DB, mk(DB, 1'b0, m6, m2), "R10"); m6 = ~m6; m2 = ~m2;
    cmd(CD, 12'h000, 1'b0);
    rd(12'h5AA, DB, DB, "R5");

    // R11 second erase ignored while erasing
    cmd(CE, 12'h3F0, 1'b0);
    m6 = 0; m2 = 0;
    cmd(CE, 12'h9F0, 1'b0);
    rd(12'h900, DA, mk(DA, DA[7], m6, DA[2]), "R11"); m6 = ~m6;
    rd(12'h300, DB, mk(DB, 1'b0, m6, m2), "R11"); m6 = ~m6; m2 = ~m2;
    cmd(CD, 12'h000, 1'b0);
    rd(12'h300, DB, DB, "R11");

    cmd(5'b00000, 12'h000, 1'b0);
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_fail++;
      $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
    end
    done_f = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule